// File: doc/BRIEF.md
# UART Receive Byte Queue with Threshold and Idle Timeout

This block holds received bytes for a UART controller until the host reads them. Bytes come in from the serial deserializer, or from the transmit-side loopback path when loopback is selected. A detected line break also counts as an arrival and pushes a zero byte. The host removes one byte per pop request. The byte appears on a registered output in the cycle after the pop.

The block keeps three status flags: empty, full, and threshold reached. It also raises two sticky interrupt causes. The overrun cause is set when a byte arrives while the queue is full; that byte is dropped. The idle-timeout cause is set when no byte has been accepted for four character times since the last accepted one.

The threshold is held in an internal register that resets to 32 and can be rewritten. The character time is a live input that is sampled at each accepted push. A synchronous receive reset empties the queue.

Top module: `uart_rx_queue`

## Requirements
- R1: Arrivals and pops are ignored while `rxEnable` is low or `rxDisable` is high. In that state `fillCount`, the flags, the stored bytes and `popData` all stay unchanged.
- R2: Bytes are returned in arrival order, including after the write position wraps past entry DEPTH-1 (default depth 64). `popData` is valid in the cycle after the pop edge.
- R3: A pop from an empty queue returns 0x00 and leaves `emptyFlag` at 1. A pop that takes the count to zero sets `emptyFlag`. An accepted arrival clears it.
- R4: `fullFlag` is 1 exactly when the count reaches DEPTH. An arrival while full is discarded, leaves the count at DEPTH and sets `overrunIrq`. `overrunIrq` stays set until a pulse on `clrOverrun`.
- R5: An accepted arrival that leaves the count at or above the threshold sets `trigFlag`. A pop that leaves the count below the threshold clears it.
- R6: The threshold resets to 32. A pulse on `trigWr` loads `trigIn` into it.
- R7: Each accepted arrival reloads an idle counter with 4×`charTime`. `timeoutIrq` rises on the 4×`charTime`-th clock edge after the last accepted arrival. It stays set until a pulse on `clrTimeout`. A `charTime` of 0 never fires.
- R8: When `breakDet` is high, exactly one byte of value 0x00 is stored. This holds even if a data byte is offered in the same cycle.
- R9: An accepted arrival and a pop of a non-empty queue in the same cycle leave the count unchanged.
- R10: A high `rxReset` empties the queue on the next edge: the count becomes 0, `emptyFlag` becomes 1, and `fullFlag` and `trigFlag` become 0. This happens regardless of the enable inputs.
- R11: With `loopMode` = 1 the byte source is `loopValid`/`loopData`. With `loopMode` = 0 the source is `rxValid`/`rxData`. The source that is not selected is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receiver enable |
| rxDisable | input | 1 | Receiver disable; overrides rxEnable |
| rxReset | input | 1 | Synchronous queue clear |
| loopMode | input | 1 | Selects the loopback byte source |
| rxValid | input | 1 | Deserializer byte strobe |
| rxData | input | 8 | Deserializer byte |
| loopValid | input | 1 | Loopback byte strobe |
| loopData | input | 8 | Loopback byte |
| breakDet | input | 1 | Line break detected; pushes 0x00 |
| popReq | input | 1 | Host pop request |
| popData | output | 8 | Byte returned by the last pop |
| trigWr | input | 1 | Load strobe for the threshold |
| trigIn | input | 7 | New threshold value |
| charTime | input | 16 | One character time in clock cycles |
| clrOverrun | input | 1 | Clears overrunIrq |
| clrTimeout | input | 1 | Clears timeoutIrq |
| fillCount | output | 7 | Number of bytes held |
| emptyFlag | output | 1 | Queue empty |
| fullFlag | output | 1 | Queue full |
| trigFlag | output | 1 | Threshold reached |
| overrunIrq | output | 1 | Sticky overrun cause |
| timeoutIrq | output | 1 | Sticky idle-timeout cause |

## Verification
The embedded properties are evaluated on every cycle. They check that the count never exceeds the depth, and that the empty flag never claims emptiness while bytes are held. They also check that an arrival at full raises overrun, that gated cycles leave the count and read data untouched, that a push paired with a non-empty pop keeps the count, that an empty pop yields zero, and that an expiring idle counter raises the timeout cause.

Only the directed scenarios can show the rest: data order across the pointer wrap, the zero-on-break substitution, source selection in loopback, the exact cycle of the timeout and its restart by a later byte, and the reset value of the threshold.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic rdZero;
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int CHAR_W   = 16,
  parameter int TRIG_RST = 32,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1,
  localparam int TMR_W   = CHAR_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              rxDisable,
  input  logic              rxReset,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              trigWr,
  input  logic [CNT_W-1:0]  trigIn,
  input  logic [CHAR_W-1:0] charTime,
  input  logic              clrOverrun,
  input  logic              clrTimeout,
  output rxqStrobe_t        strb,
  output logic [PTR_W-1:0]  wrIdx,
  output logic [PTR_W-1:0]  rdIdx,
  output logic [CNT_W-1:0]  fillCount,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              trigFlag,
  output logic              overrunIrq,
  output logic              timeoutIrq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wptr;
  logic [CNT_W-1:0] cnt, nextCnt, trigLvl;
  logic [TMR_W-1:0] idleTmr;
  logic enabled, isFull, pushAcc, pushOvr, popAcc, popHit, expire;

  assign enabled = rxEnable & ~rxDisable;
  assign isFull  = (cnt == FULL_CNT);
  assign pushAcc = enabled & pushReq & ~isFull & ~rxReset;
  assign pushOvr = enabled & pushReq & isFull & ~rxReset;
  assign popAcc  = enabled & popReq & ~rxReset;
  assign popHit  = popAcc & (cnt != '0);
  assign expire  = ~rxReset & ~pushAcc & (idleTmr == TMR_W'(1));

  always_comb begin
    case ({pushAcc, popHit})
      2'b10:   nextCnt = cnt + CNT_W'(1);
      2'b01:   nextCnt = cnt - CNT_W'(1);
      default: nextCnt = cnt;
    endcase
  end

  assign wrIdx       = wptr;
  assign rdIdx       = wptr - cnt[PTR_W-1:0];
  assign strb.wrEn   = pushAcc;
  assign strb.rdEn   = popAcc;
  assign strb.rdZero = (cnt == '0);
  assign fillCount   = cnt;

  // threshold register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       trigLvl <= CNT_W'(TRIG_RST);
    else if (trigWr) trigLvl <= trigIn;
  end

  // pointer, count and status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wptr <= '0; cnt <= '0;
      emptyFlag <= 1'b1; fullFlag <= 1'b0; trigFlag <= 1'b0;
    end else if (rxReset) begin
      wptr <= '0; cnt <= '0;
      emptyFlag <= 1'b1; fullFlag <= 1'b0; trigFlag <= 1'b0;
    end else begin
      if (pushAcc) wptr <= wptr + PTR_W'(1);
      cnt <= nextCnt;
      if (pushAcc || popAcc) begin
        emptyFlag <= (nextCnt == '0);
        fullFlag  <= (nextCnt == FULL_CNT);
      end
      if (pushAcc && nextCnt >= trigLvl)     trigFlag <= 1'b1;
      else if (popAcc && nextCnt < trigLvl)  trigFlag <= 1'b0;
    end
  end

  // idle timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  idleTmr <= '0;
    else if (rxReset)           idleTmr <= '0;
    else if (pushAcc)           idleTmr <= {charTime, 2'b00};
    else if (idleTmr != '0)     idleTmr <= idleTmr - TMR_W'(1);
  end

  // sticky causes: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrunIrq <= 1'b0;
      timeoutIrq <= 1'b0;
    end else begin
      overrunIrq <= (overrunIrq & ~clrOverrun) | pushOvr;
      timeoutIrq <= (timeoutIrq & ~clrTimeout) | expire;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= FULL_CNT);  // R4
  AST_FULL_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    (enabled && pushReq && isFull && !rxReset) |=> overrunIrq);  // R4
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !rxReset) |=> $stable(cnt));  // R1
  AST_EMPTY_TRUE: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag |-> (cnt == '0));  // R3
  AST_PAIR_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (pushAcc && popHit) |=> $stable(cnt));  // R9
  AST_IDLE_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    (idleTmr == TMR_W'(1) && !pushAcc && !rxReset) |=> timeoutIrq);  // R7
endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxqStrobe_t        strb,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] wrByte,
  output logic [DATA_W-1:0] popData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrIdx] <= wrByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          popData <= '0;
    else if (strb.rdEn) popData <= strb.rdZero ? '0 : mem[rdIdx];
  end

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdZero) |=> (popData == '0));  // R3
  AST_NO_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(popData));  // R1
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int DATA_W   = 8,
  parameter int CHAR_W   = 16,
  parameter int TRIG_RST = 32,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              rxDisable,
  input  logic              rxReset,
  input  logic              loopMode,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              loopValid,
  input  logic [DATA_W-1:0] loopData,
  input  logic              breakDet,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  input  logic              trigWr,
  input  logic [CNT_W-1:0]  trigIn,
  input  logic [CHAR_W-1:0] charTime,
  input  logic              clrOverrun,
  input  logic              clrTimeout,
  output logic [CNT_W-1:0]  fillCount,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              trigFlag,
  output logic              overrunIrq,
  output logic              timeoutIrq
);
  rxqStrobe_t        strb;
  logic [PTR_W-1:0]  wrIdx, rdIdx;
  logic              pushReq;
  logic [DATA_W-1:0] wrByte;

  // source select; a break substitutes a zero byte
  always_comb begin
    pushReq = breakDet | (loopMode ? loopValid : rxValid);
    if (breakDet)      wrByte = '0;
    else if (loopMode) wrByte = loopData;
    else               wrByte = rxData;
  end

  rxq_ctrl #(.DEPTH(DEPTH), .CHAR_W(CHAR_W), .TRIG_RST(TRIG_RST)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .rxDisable(rxDisable),
    .rxReset(rxReset), .pushReq(pushReq), .popReq(popReq),
    .trigWr(trigWr), .trigIn(trigIn), .charTime(charTime),
    .clrOverrun(clrOverrun), .clrTimeout(clrTimeout),
    .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx), .fillCount(fillCount),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag), .trigFlag(trigFlag),
    .overrunIrq(overrunIrq), .timeoutIrq(timeoutIrq)
  );

  rxq_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrByte(wrByte), .popData(popData)
  );
endmodule

// File: tb/sim_uart_rx_queue.sv
`timescale 1ns/1ps
module sim_uart_rx_queue;
  logic clk = 0, rstN = 0;
  logic rxEnable = 1, rxDisable = 0, rxReset = 0, loopMode = 0;
  logic rxValid = 0, loopValid = 0, breakDet = 0, popReq = 0;
  logic [7:0] rxData = 0, loopData = 0, popData;
  logic trigWr = 0, clrOverrun = 0, clrTimeout = 0;
  logic [6:0] trigIn = 0, fillCount;
  logic [15:0] charTime = 0;
  logic emptyFlag, fullFlag, trigFlag, overrunIrq, timeoutIrq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_queue u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushB(input logic [7:0] b);
    @(negedge clk); rxValid = 1; rxData = b;
    @(negedge clk); rxValid = 0;
  endtask

  task automatic popB();
    @(negedge clk); popReq = 1;
    @(negedge clk); popReq = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rxReset = 1;
    @(negedge clk); rxReset = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tReset();
    chk("R3 empty at reset", emptyFlag, 1);
    chk("R4 full at reset", fullFlag, 0);
    chk("R10 count at reset", fillCount, 0);
    chk("R7 timeout at reset", timeoutIrq, 0);
  endtask

  task automatic tTrigDefault();
    for (int i = 0; i < 31; i++) pushB(8'(i));
    chk("R6 below default threshold", trigFlag, 0);
    pushB(8'd31);
    chk("R6 default threshold 32", trigFlag, 1);
    popB();
    chk("R5 pop below threshold clears", trigFlag, 0);
    chk("R2 first byte", popData, 0);
    doReset();
    chk("R10 count cleared", fillCount, 0);
    chk("R10 empty set", emptyFlag, 1);
  endtask

  task automatic tTrigProg();
    @(negedge clk); trigWr = 1; trigIn = 7'd3;
    @(negedge clk); trigWr = 0;
    pushB(1); pushB(2);
    chk("R5 two below level 3", trigFlag, 0);
    pushB(3);
    chk("R5 level 3 reached", trigFlag, 1);
    pushB(4); popB();
    chk("R5 count 3 keeps flag", trigFlag, 1);
    popB();
    chk("R5 count 2 clears flag", trigFlag, 0);
    doReset();
  endtask

  task automatic tWrapOrder();
    for (int i = 0; i < 60; i++) pushB(8'hFF);
    for (int i = 0; i < 60; i++) popB();
    for (int i = 0; i < 8; i++) pushB(8'(8'h40 + i));
    for (int i = 0; i < 8; i++) begin
      popB();
      chk("R2 order across wrap", popData, 8'h40 + i);
    end
    chk("R3 drained empty", emptyFlag, 1);
  endtask

  task automatic tFullOverrun();
    doReset();
    for (int i = 0; i < 64; i++) pushB(8'(i) ^ 8'hA5);
    chk("R4 full flag", fullFlag, 1);
    chk("R4 no overrun yet", overrunIrq, 0);
    pushB(8'hEE);
    chk("R4 overrun set", overrunIrq, 1);
    chk("R4 count stays", fillCount, 64);
    for (int i = 0; i < 64; i++) begin
      popB();
      chk("R4 stored data kept", popData, 8'(i) ^ 8'hA5);
    end
    chk("R4 full cleared", fullFlag, 0);
    chk("R4 overrun sticky", overrunIrq, 1);
    @(negedge clk); clrOverrun = 1;
    @(negedge clk); clrOverrun = 0;
    chk("R4 overrun cleared", overrunIrq, 0);
  endtask

  task automatic tGating();
    pushB(8'h0A); pushB(8'h0B); popB();
    rxEnable = 0;
    pushB(8'h0C); popB();
    chk("R1 off: count held", fillCount, 1);
    chk("R1 off: data held", popData, 8'h0A);
    rxEnable = 1; rxDisable = 1;
    pushB(8'h0D); popB();
    chk("R1 disable: count held", fillCount, 1);
    chk("R1 disable: data held", popData, 8'h0A);
    rxDisable = 0;
    popB();
    chk("R1 re-enabled pop", popData, 8'h0B);
  endtask

  task automatic tBreak();
    @(negedge clk); breakDet = 1; rxValid = 1; rxData = 8'h77;
    @(negedge clk); breakDet = 0; rxValid = 0;
    chk("R8 one entry", fillCount, 1);
    pushB(8'h55); popB();
    chk("R8 zero byte stored", popData, 0);
    popB();
    chk("R8 next byte intact", popData, 8'h55);
  endtask

  task automatic tLoop();
    loopMode = 1;
    @(negedge clk); loopValid = 1; loopData = 8'h3C; rxValid = 1; rxData = 8'h99;
    @(negedge clk); loopValid = 0; rxValid = 0;
    chk("R11 one entry from loop", fillCount, 1);
    popB();
    chk("R11 loop byte", popData, 8'h3C);
    @(negedge clk); rxValid = 1; rxData = 8'h12;
    @(negedge clk); rxValid = 0;
    chk("R11 deserializer ignored", fillCount, 0);
    loopMode = 0;
  endtask

  task automatic tPopEmpty();
    popB();
    chk("R3 empty pop zero", popData, 0);
    chk("R3 empty flag", emptyFlag, 1);
    chk("R3 count zero", fillCount, 0);
  endtask

  task automatic tSimul();
    pushB(8'h11); pushB(8'h22);
    @(negedge clk); rxValid = 1; rxData = 8'h33; popReq = 1;
    @(negedge clk); rxValid = 0; popReq = 0;
    chk("R9 count unchanged", fillCount, 2);
    chk("R9 popped oldest", popData, 8'h11);
    popB(); chk("R9 second", popData, 8'h22);
    popB(); chk("R9 third", popData, 8'h33);
  endtask

  task automatic tTimeout();
    charTime = 16'd3;
    pushB(8'h01);
    idle(11);
    chk("R7 not yet at 11", timeoutIrq, 0);
    idle(1);
    chk("R7 fires at 12", timeoutIrq, 1);
    @(negedge clk); clrTimeout = 1;
    @(negedge clk); clrTimeout = 0;
    chk("R7 cleared", timeoutIrq, 0);
    pushB(8'h02);
    idle(5);
    pushB(8'h03);
    idle(11);
    chk("R7 restarted by later byte", timeoutIrq, 0);
    idle(1);
    chk("R7 fires after restart", timeoutIrq, 1);
    charTime = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tTrigDefault();
    tTrigProg();
    tWrapOrder();
    tFullOverrun();
    tGating();
    tBreak();
    tLoop();
    tPopEmpty();
    tSimul();
    tTimeout();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule